// File: doc/BRIEF.md
# Line Buffer Pixel Decoder

This block scans the read bank of a scanline buffer and turns each stored 5-bit word into one or two output pixels. Every pixel leaves the block as a 3-bit palette index and a 2-bit color index, or as a background flag. Looking up the final color in the palette registers happens further down the pipeline.

A one-cycle line-start pulse latches the two-bit read mode and sends the read address back to word 0. The block then walks the words in ascending order, one word per cycle in the single-pixel mode and one word per two cycles in the two-pixel modes. Each pixel comes out on a valid strobe. The buffer is read combinationally: the block drives the address and the word comes back in the same cycle. Once the last beat of word 159 has been emitted, the scan stops and waits for the next line start.

Top module: `lbuf_pix_decode`

## Requirements
- R1: After reset, pix_valid is 0 and rd_addr is 0.
- R2: The cycle in which line_start is high produces no pixel. The next cycle reads address 0 and its pixel appears one clock later. A line start during a scan abandons that scan and restarts it.
- R3: In read mode 2'b00 and in read mode 2'b01, each word w gives exactly one pixel: palette w[4:2], color w[1:0]. A line has 160 pixels in address order.
- R4: A pixel whose two color bits are both 0 is background: pix_bg is 1 and pix_pal and pix_col are both 0. Every other pixel has pix_bg at 0 and a nonzero pix_col.
- R5: In read mode 2'b10, each word w gives two pixels, 320 per line. Both pixels have palette {w[4],2'b00}. The first pixel's color is {w[1],w[3]} and the second pixel's color is {w[0],w[2]}.
- R6: In read mode 2'b11, each word w gives two pixels with palette w[4:2]. The first pixel has color 2'b10 when w[1] is 1 and is background otherwise. The second pixel does the same using w[0].
- R7: The word 5'b10101 gives palette 5, color 1 in mode 00. In mode 10 it gives background, then palette 4, color 3. In mode 11 it gives background, then palette 5, color 2.
- R8: After the last pixel of word 159, pix_valid goes low and stays low until the next line start. rd_addr never goes past 159.
- R9: The read mode is sampled only in the line-start cycle. Changing read_mode during a scan has no effect on that line's pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | One-cycle pulse that starts a scan at word 0 |
| read_mode | input | 2 | Read mode, sampled at line_start |
| rd_addr | output | 8 | Line buffer read address |
| rd_word | input | 5 | Word read at rd_addr, same cycle |
| pix_valid | output | 1 | Pixel outputs are valid this cycle |
| pix_bg | output | 1 | Pixel is background |
| pix_pal | output | 3 | Palette index (0 when background) |
| pix_col | output | 2 | Color index (0 when background) |

## Verification
The buffer holds a stride pattern in which every one of the 32 word values appears several times. That pattern is scanned in all four read modes, so each bit of each word is seen in both half-pixel positions. This separates a swapped or swizzled color bit, a wrong forced palette bit and a mistaken background decision. The 10101 word sits at a fixed address, and its pixels are compared with literal values.

Other runs cover the remaining sequencing cases. One scan changes read_mode partway through, which checks that the mode is held for the whole line. Another scan is cut off by a second line start, which shows the gap cycle and the restart at word 0. Full scans check that the strobe goes low after word 159, with the beat count telling one-pixel modes from two-pixel modes.

// File: rtl/lbd_pkg.sv
package lbd_pkg;

  localparam int WORD_W = 5;

  typedef enum logic [1:0] {
    RM_NARROW = 2'b00,
    RM_ALIAS  = 2'b01,
    RM_SWZ    = 2'b10,
    RM_PAIR   = 2'b11
  } rmode_t;

  typedef struct packed {
    logic       bg;
    logic [2:0] pal;
    logic [1:0] col;
  } pix_t;

  function automatic logic is_dual(input logic [1:0] mode);
    return mode[1];
  endfunction

  function automatic pix_t decode_word(input logic [1:0] mode,
                                       input logic [WORD_W-1:0] w,
                                       input logic second);
    pix_t p;
    logic sel;
    sel   = second ? w[0] : w[1];
    p.pal = w[4:2];
    p.col = w[1:0];
    case (rmode_t'(mode))
      RM_SWZ: begin
        p.pal = {w[4], 2'b00};
        p.col = second ? {w[0], w[2]} : {w[1], w[3]};
      end
      RM_PAIR: begin
        p.col = {sel, 1'b0};
      end
      default: ;
    endcase
    p.bg = (p.col == 2'b00);
    if (p.bg) begin
      p.pal = 3'd0;
      p.col = 2'd0;
    end
    return p;
  endfunction

endpackage

// File: rtl/lbd_addr_seq.sv
module lbd_addr_seq #(
  parameter int WORDS = 160,
  parameter int AW    = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          dual,
  output logic [AW-1:0] addr,
  output logic          second,
  output logic          active,
  output logic          last_beat
);
  localparam logic [AW-1:0] LAST = AW'(WORDS - 1);

  assign last_beat = active && (addr == LAST) && (!dual || second);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr   <= '0;
      second <= 1'b0;
      active <= 1'b0;
    end else if (start) begin
      addr   <= '0;
      second <= 1'b0;
      active <= 1'b1;
    end else if (active) begin
      if (dual && !second) begin
        second <= 1'b1;
      end else begin
        second <= 1'b0;
        if (addr == LAST) active <= 1'b0;
        else               addr   <= addr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lbd_word_split.sv
module lbd_word_split
  import lbd_pkg::*;
(
  input  logic [1:0]        mode,
  input  logic [WORD_W-1:0] word,
  input  logic              second,
  output pix_t              pix
);
  always_comb pix = decode_word(mode, word, second);
endmodule

// File: rtl/lbd_out_stage.sv
module lbd_out_stage
  import lbd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  pix_t pix_in,
  output logic valid,
  output pix_t pix_out
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      pix_out <= '0;
    end else begin
      valid <= load;
      if (load) pix_out <= pix_in;
    end
  end
endmodule

// File: rtl/lbuf_pix_decode.sv
module lbuf_pix_decode
  import lbd_pkg::*;
#(
  parameter int WORDS = 160,
  parameter int AW    = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic [1:0]        read_mode,
  output logic [AW-1:0]     rd_addr,
  input  logic [WORD_W-1:0] rd_word,
  output logic              pix_valid,
  output logic              pix_bg,
  output logic [2:0]        pix_pal,
  output logic [1:0]        pix_col
);
  logic [1:0] mode_q;
  logic       second, active, last_beat, load;
  pix_t       pix_d, pix_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          mode_q <= RM_NARROW;
    else if (line_start) mode_q <= read_mode;
  end

  lbd_addr_seq #(.WORDS(WORDS), .AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(line_start), .dual(is_dual(mode_q)),
    .addr(rd_addr), .second(second), .active(active), .last_beat(last_beat)
  );

  lbd_word_split u_split (
    .mode(mode_q), .word(rd_word), .second(second), .pix(pix_d)
  );

  assign load = active && !line_start;

  lbd_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .load(load), .pix_in(pix_d),
    .valid(pix_valid), .pix_out(pix_q)
  );

  assign pix_bg  = pix_q.bg;
  assign pix_pal = pix_q.pal;
  assign pix_col = pix_q.col;
endmodule

// File: rtl/lbd_checker.sv
module lbd_checker #(
  parameter int WORDS = 160,
  parameter int AW    = $clog2(WORDS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          line_start,
  input logic [1:0]    mode_q,
  input logic          active,
  input logic          second,
  input logic          last_beat,
  input logic [AW-1:0] rd_addr,
  input logic          pix_valid,
  input logic          pix_bg,
  input logic [2:0]    pix_pal,
  input logic [1:0]    pix_col
);
  localparam logic [AW-1:0] LAST = AW'(WORDS - 1);

  a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> (rd_addr == '0 && active && !second && !pix_valid));

  a_r4_bg_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_bg) |-> (pix_pal == 3'd0 && pix_col == 2'd0));

  a_r4_color_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_bg) |-> (pix_col != 2'd0));

  a_r5_forced_palette: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && mode_q == 2'b10) |-> (pix_pal[1:0] == 2'b00));

  a_r6_pair_color: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && mode_q == 2'b11 && !pix_bg) |-> (pix_col == 2'b10));

  a_r8_addr_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr <= LAST);

  a_r8_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (last_beat && !line_start) |=> (!active ##1 !pix_valid));

  a_r9_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |=> $stable(mode_q));
endmodule

bind lbuf_pix_decode lbd_checker #(.WORDS(WORDS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_start(line_start), .mode_q(mode_q),
  .active(active), .second(second), .last_beat(last_beat), .rd_addr(rd_addr),
  .pix_valid(pix_valid), .pix_bg(pix_bg), .pix_pal(pix_pal), .pix_col(pix_col)
);

// File: tb/lbuf_pix_decode_tb.sv
module lbuf_pix_decode_tb;
  localparam int WORDS = 160;
  localparam int AW    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_start = 1'b0;
  logic [1:0] read_mode = 2'b00;
  logic [AW-1:0] rd_addr;
  logic [4:0] rd_word;
  logic pix_valid, pix_bg;
  logic [2:0] pix_pal;
  logic [1:0] pix_col;

  logic [4:0] mem [WORDS];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  assign rd_word = (rd_addr < WORDS) ? mem[rd_addr] : 5'd0;

  lbuf_pix_decode #(.WORDS(WORDS), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .read_mode(read_mode),
    .rd_addr(rd_addr), .rd_word(rd_word), .pix_valid(pix_valid),
    .pix_bg(pix_bg), .pix_pal(pix_pal), .pix_col(pix_col)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // packs {bg, pal, col} into one integer for compare
  function automatic int expect_pix(input logic [1:0] m, input logic [4:0] w,
                                    input bit h);
    bit c1, c0;
    int pal;
    if (m == 2'b10) begin
      c1 = h ? w[0] : w[1];
      c0 = h ? w[2] : w[3];
      pal = w[4] * 4;
    end else if (m == 2'b11) begin
      c1 = h ? w[0] : w[1];
      c0 = 0;
      pal = w[4] * 4 + w[3] * 2 + w[2];
    end else begin
      c1 = w[1];
      c0 = w[0];
      pal = w[4] * 4 + w[3] * 2 + w[2];
    end
    if (!(c1 | c0)) return 64;
    return pal * 4 + c1 * 2 + c0;
  endfunction

  task automatic run_line(input logic [1:0] m, input int nbeats,
                          input int chg_at, input logic [1:0] alt);
    int full;
    full = m[1] ? 2 * WORDS : WORDS;
    read_mode  = m;
    line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    chk(pix_valid == 1'b0, "R2", "valid in start cycle", int'(pix_valid), 0);
    for (int j = 0; j < nbeats; j++) begin
      int a, exp, act;
      bit h;
      string tag;
      @(negedge clk);
      if (j == chg_at) read_mode = alt;
      a = m[1] ? j / 2 : j;
      h = m[1] ? bit'(j % 2) : 1'b0;
      exp = expect_pix(m, mem[a], h);
      act = pix_bg ? 64 : (int'(pix_pal) * 4 + int'(pix_col));
      if (pix_bg && (pix_pal != 0 || pix_col != 0)) act = 99;
      if (chg_at >= 0 && j > chg_at) tag = "R9";
      else if (exp == 64) tag = "R4";
      else if (m == 2'b10) tag = "R5";
      else if (m == 2'b11) tag = "R6";
      else tag = "R3";
      chk(pix_valid == 1'b1, tag, "valid during scan", int'(pix_valid), 1);
      chk(act == exp, tag, $sformatf("pixel beat %0d", j), act, exp);
      if (a == 7) begin
        int lit;
        if (m == 2'b10) lit = h ? (4 * 4 + 3) : 64;
        else if (m == 2'b11) lit = h ? (5 * 4 + 2) : 64;
        else lit = 5 * 4 + 1;
        chk(act == lit, "R7", "word 10101", act, lit);
      end
    end
    if (nbeats == full) begin
      @(negedge clk);
      chk(pix_valid == 1'b0, "R8", "valid after last word", int'(pix_valid), 0);
      @(negedge clk);
      chk(pix_valid == 1'b0, "R8", "valid stays low", int'(pix_valid), 0);
      chk(rd_addr <= WORDS - 1, "R8", "address bound", int'(rd_addr), WORDS - 1);
    end
  endtask

  initial begin
    for (int i = 0; i < WORDS; i++) mem[i] = 5'((i * 7) + (i / 32));
    mem[7] = 5'b10101;
    repeat (3) @(negedge clk);
    chk(pix_valid == 1'b0, "R1", "valid in reset", int'(pix_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pix_valid == 1'b0, "R1", "valid after reset", int'(pix_valid), 0);
    chk(rd_addr == 0, "R1", "address after reset", int'(rd_addr), 0);
    run_line(2'b00, WORDS, -1, 2'b00);
    run_line(2'b01, WORDS, -1, 2'b01);
    run_line(2'b10, 2 * WORDS, -1, 2'b10);
    run_line(2'b11, 2 * WORDS, 20, 2'b00);
    run_line(2'b10, 2 * WORDS, 33, 2'b11);
    run_line(2'b00, 50, -1, 2'b00);
    run_line(2'b10, 2 * WORDS, -1, 2'b10);
    run_line(2'b11, 2 * WORDS, -1, 2'b11);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule